// File: doc/BRIEF.md
# Split 32-bit General Purpose I/O Port

This block gives software control of thirty-two general purpose pins through a small register bus. Every pin has a direction bit (1 makes it an output) and a data bit. Sixteen pins sit on dedicated pads. The other sixteen share the pads of the external data bus. Each of the four registers is one half-word wide. The lower pins are reached at two addresses and the upper pins at two more. A byte write strobe selects which eight-pin group a write touches.

A read of a data register returns a mix of two sources. A pin set as input returns its synchronised pad level. A pin set as output returns its output latch. Changing a direction bit moves state between pad and latch. A pin that becomes an output drives its stored latch value. A pin that becomes an input copies its present synchronised pad level into its latch.

The shared upper pins are available only when two static configuration inputs report an 8-bit memory bus with the SDRAM controller switched off. In any other configuration the upper pins are released, their writes are dropped and their reads return zero. Pads are modelled as separate in, out and enable vectors. The register bus and configuration pins are plain control signals with no handshake. The bus accepts one access per cycle and never stalls.

Top module: `split_gpio_port`

## Requirements
- R1: After reset every direction bit and every data bit is 0, so both output-enable vectors are 0.
- R2: Register addresses are: 0 for lower direction, 1 for lower data, 2 for upper direction and 3 for upper data. Bit i at addresses 0 and 1 controls pin i. Bit i at addresses 2 and 3 controls pin 16+i. A direction bit of 1 sets that pin's enable, and a direction bit of 0 clears it.
- R3: A data register read returns the pad level for each input pin. A pad change is visible after exactly two rising clock edges and not after one.
- R4: For an output pin, the pad value follows the data bit written, starting on the clock edge that takes the write.
- R5: When a pin turns from input to output, it drives the value its data bit already held.
- R6: When a pin turns from output to input, its data bit takes the synchronised pad level seen in that cycle.
- R7: A write changes only the byte lanes whose strobe bit is set. Strobe bit 0 covers register bits 7:0 and strobe bit 1 covers bits 15:8. Other lanes keep their direction and data.
- R8: Changing the direction or data of one pin leaves the direction and data of every other pin unchanged, including pins in the other half.
- R9: The upper half is enabled only when the 8-bit memory input is 1 and the SDRAM-enable input is 0. While it is disabled, its enables are 0, writes to addresses 2 and 3 are ignored and reads of those addresses return 0. The stored state reappears when the half is enabled again.
- R10: A data register read returns the latch value for each output pin, whatever level is on the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mem8 | input | 1 | All memory areas configured 8 bits wide |
| cfg_sdram_en | input | 1 | SDRAM controller enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wstrb | input | 2 | Byte lane write enables |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| pio_in | input | 16 | Lower pad input levels |
| pio_out | output | 16 | Lower pad output values |
| pio_oe | output | 16 | Lower pad output enables |
| dbus_in | input | 16 | Upper (shared data bus) pad input levels |
| dbus_out | output | 16 | Upper pad output values |
| dbus_oe | output | 16 | Upper pad output enables |

## Verification
A corrupted direction bit appears on the enable vector at the next clock edge. It also changes which source a data read returns for that pin. A corrupted latch appears on the pad output directly, and on reads only for output pins. For this reason the tests toggle each pin back to output after a capture, which brings the captured latch value out to the pads. A fault in the synchroniser or in the capture path shows up as a one-edge shift in read timing, or as a wrong nibble after a turn-around. A gating fault shows up as a driven upper enable, or as state that survives a write the port should have dropped.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;
  typedef enum logic [1:0] {
    REG_LO_DIR = 2'd0,
    REG_LO_DAT = 2'd1,
    REG_HI_DIR = 2'd2,
    REG_HI_DAT = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int W      = 16,
  parameter int LANE_W = 8,
  localparam int NLANE = W / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_en_i,
  input  logic             wr_dir_i,
  input  logic             wr_dat_i,
  input  logic [NLANE-1:0] wstrb_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     pin_i,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     dat_o,
  output logic [W-1:0]     rd_dat_o
);
  logic [W-1:0] dir_q, dat_q;
  logic [W-1:0] wmask;
  logic [W-1:0] dir_nxt;
  logic [W-1:0] falling;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign wmask[l*LANE_W +: LANE_W] = {LANE_W{wstrb_i[l]}};

    AST_LANE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_en_i && (wr_dir_i || wr_dat_i) && !wstrb_i[l]) |=>
        ($stable(dir_q[l*LANE_W +: LANE_W]) && $stable(dat_q[l*LANE_W +: LANE_W]))); // R7
  end

  assign dir_nxt = (dir_q & ~wmask) | (wdata_i & wmask);
  assign falling = dir_q & ~dir_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (bank_en_i && wr_dir_i) begin
      dir_q <= dir_nxt;
      dat_q <= (dat_q & ~falling) | (pin_i & falling);
    end else if (bank_en_i && wr_dat_i) begin
      dat_q <= (dat_q & ~wmask) | (wdata_i & wmask);
    end
  end

  assign dir_o    = dir_q;
  assign dat_o    = dat_q;
  assign rd_dat_o = (dir_q & dat_q) | (~dir_q & pin_i);

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_en_i |=> ($stable(dir_q) && $stable(dat_q))); // R9

  AST_DIR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_en_i && wr_dir_i) |=> $stable(dir_q)); // R8

  AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en_i && wr_dir_i) |=>
      ((($past(dir_q) & ~dir_q) & (dat_q ^ $past(pin_i))) == '0)); // R6

  AST_DAT_KEEP_ON_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en_i && wr_dir_i) |=>
      (((dat_q ^ $past(dat_q)) & ~($past(dir_q) & ~dir_q)) == '0)); // R8
endmodule

// File: rtl/split_gpio_port.sv
module split_gpio_port
  import gpio_split_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LANE_W = 8,
  localparam int NLANE = HALF_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mem8,
  input  logic              cfg_sdram_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [NLANE-1:0]  reg_wstrb,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  input  logic [HALF_W-1:0] pio_in,
  output logic [HALF_W-1:0] pio_out,
  output logic [HALF_W-1:0] pio_oe,
  input  logic [HALF_W-1:0] dbus_in,
  output logic [HALF_W-1:0] dbus_out,
  output logic [HALF_W-1:0] dbus_oe
);
  logic upper_en;
  logic [HALF_W-1:0] lo_sync, hi_sync;
  logic [HALF_W-1:0] lo_dir, lo_dat, lo_rd;
  logic [HALF_W-1:0] hi_dir, hi_dat, hi_rd;
  gpio_reg_e sel;

  assign upper_en = cfg_mem8 && !cfg_sdram_en;
  assign sel      = gpio_reg_e'(reg_addr);

  gpio_pin_sync #(.W(HALF_W)) u_lo_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pio_in), .sync_o(lo_sync));
  gpio_pin_sync #(.W(HALF_W)) u_hi_sync (
    .clk(clk), .rst_n(rst_n), .async_i(dbus_in), .sync_o(hi_sync));

  gpio_pin_bank #(.W(HALF_W), .LANE_W(LANE_W)) u_lo_bank (
    .clk(clk), .rst_n(rst_n), .bank_en_i(1'b1),
    .wr_dir_i(reg_wr && sel == REG_LO_DIR),
    .wr_dat_i(reg_wr && sel == REG_LO_DAT),
    .wstrb_i(reg_wstrb), .wdata_i(reg_wdata), .pin_i(lo_sync),
    .dir_o(lo_dir), .dat_o(lo_dat), .rd_dat_o(lo_rd));

  gpio_pin_bank #(.W(HALF_W), .LANE_W(LANE_W)) u_hi_bank (
    .clk(clk), .rst_n(rst_n), .bank_en_i(upper_en),
    .wr_dir_i(reg_wr && sel == REG_HI_DIR),
    .wr_dat_i(reg_wr && sel == REG_HI_DAT),
    .wstrb_i(reg_wstrb), .wdata_i(reg_wdata), .pin_i(hi_sync),
    .dir_o(hi_dir), .dat_o(hi_dat), .rd_dat_o(hi_rd));

  assign pio_out  = lo_dat;
  assign pio_oe   = lo_dir;
  assign dbus_out = hi_dat;
  assign dbus_oe  = hi_dir & {HALF_W{upper_en}};

  always_comb begin
    unique case (sel)
      REG_LO_DIR: reg_rdata = lo_dir;
      REG_LO_DAT: reg_rdata = lo_rd;
      REG_HI_DIR: reg_rdata = upper_en ? hi_dir : '0;
      REG_HI_DAT: reg_rdata = upper_en ? hi_rd  : '0;
      default:    reg_rdata = '0;
    endcase
  end

  AST_UPPER_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_en |-> (dbus_oe == '0)); // R9

  AST_UPPER_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!upper_en && reg_addr[1]) |-> (reg_rdata == '0)); // R9

  AST_LO_OE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel == REG_LO_DIR) |=> $stable(pio_oe)); // R8
endmodule

// File: tb/split_gpio_port_bench.sv
module split_gpio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mem8 = 1'b0, cfg_sdram_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [1:0]  reg_wstrb = 2'b00;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] pio_in = '0, pio_out, pio_oe;
  logic [15:0] dbus_in = '0, dbus_out, dbus_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  split_gpio_port u_split_gpio_port (
    .clk(clk), .rst_n(rst_n), .cfg_mem8(cfg_mem8), .cfg_sdram_en(cfg_sdram_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wstrb(reg_wstrb),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pio_in(pio_in), .pio_out(pio_out), .pio_oe(pio_oe),
    .dbus_in(dbus_in), .dbus_out(dbus_out), .dbus_oe(dbus_oe));

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wstrb = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wstrb = 2'b00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1", "pio_oe", pio_oe, 16'h0000);
    chk("R1", "dbus_oe", dbus_oe, 16'h0000);
    chk("R1", "pio_out", pio_out, 16'h0000);
    rd(2'd0, d); chk("R1", "lo dir read", d, 16'h0000);
  endtask

  task automatic t_drive();
    logic [15:0] d;
    wr(2'd1, 2'b11, 16'hA5C3);
    chk("R2", "oe while input", pio_oe, 16'h0000);
    wr(2'd0, 2'b11, 16'hFFFF);
    chk("R2", "oe after dir", pio_oe, 16'hFFFF);
    chk("R5", "held value driven", pio_out, 16'hA5C3);
    wr(2'd1, 2'b11, 16'h1234);
    chk("R4", "new drive", pio_out, 16'h1234);
    rd(2'd1, d); chk("R10", "latch read vs pad 0", d, 16'h1234);
    rd(2'd0, d); chk("R2", "dir read", d, 16'hFFFF);
  endtask

  task automatic t_input_read();
    logic [15:0] d;
    wr(2'd0, 2'b11, 16'h00FF);
    pio_in = 16'hBE00;
    @(negedge clk);
    rd(2'd1, d); chk("R3", "after one edge", d, 16'h0034);
    @(negedge clk);
    rd(2'd1, d); chk("R3", "after two edges", d, 16'hBE34);
  endtask

  task automatic t_turnaround();
    wr(2'd0, 2'b11, 16'hFFFF);
    chk("R5", "captured zero driven", pio_out, 16'h0034);
    wr(2'd0, 2'b11, 16'h0FFF);
    wr(2'd0, 2'b11, 16'hFFFF);
    chk("R6", "capture nibble, R8 others kept", pio_out, 16'hB034);
  endtask

  task automatic t_strobe();
    wr(2'd0, 2'b01, 16'h0000);
    chk("R7", "low lane dir only", pio_oe, 16'hFF00);
    chk("R6", "low lane captured", pio_out, 16'hB000);
    wr(2'd1, 2'b10, 16'hFFFF);
    chk("R7", "high lane data only", pio_out, 16'hFF00);
  endtask

  task automatic t_upper();
    logic [15:0] d;
    wr(2'd2, 2'b11, 16'hFFFF);
    wr(2'd3, 2'b11, 16'h5A5A);
    chk("R9", "disabled oe", dbus_oe, 16'h0000);
    cfg_mem8 = 1'b1; cfg_sdram_en = 1'b1;
    wr(2'd2, 2'b11, 16'hFFFF);
    rd(2'd2, d); chk("R9", "sdram on read", d, 16'h0000);
    cfg_sdram_en = 1'b0;
    #1 chk("R9", "dropped writes", dbus_oe, 16'h0000);
    rd(2'd2, d); chk("R9", "dir read after enable", d, 16'h0000);
    wr(2'd3, 2'b11, 16'h5A5A);
    wr(2'd2, 2'b11, 16'h00FF);
    chk("R2", "upper oe", dbus_oe, 16'h00FF);
    chk("R4", "upper drive", dbus_out[7:0], 8'h5A);
    chk("R8", "lower untouched", pio_oe, 16'hFF00);
    dbus_in = 16'h1200;
    @(negedge clk); @(negedge clk);
    rd(2'd3, d); chk("R3", "upper mixed read", d, 16'h125A);
    cfg_sdram_en = 1'b1;
    #1 chk("R9", "released oe", dbus_oe, 16'h0000);
    rd(2'd3, d); chk("R9", "blank data read", d, 16'h0000);
    cfg_sdram_en = 1'b0;
    #1 chk("R9", "state restored", dbus_oe, 16'h00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_input_read();
    t_turnaround();
    t_strobe();
    t_upper();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule